// File: doc/BRIEF.md
# Board Control Register Slave

A 32-bit memory-mapped register slave for the control corner of a board-support region. It decodes only the low 20 bits of the bus address. Several byte-wide control registers are held here: an LED bar, a break/reset byte and a general-purpose output byte. The slave also holds an eight-character ASCII display buffer. Software can fill that buffer one character at a time, or in a single store that turns a 32-bit value into eight uppercase hexadecimal digits. A bit-banged two-wire (I2C) port is driven from its own output-enable, output-level and select registers, and reads the live data line back. A keyed software-reset register gives a one-cycle reset request, but only when the exact key value is written.

Writes take effect on the clock edge where the write strobe is high. Read data is a combinational function of the address. A read-valid flag follows one cycle after the read strobe.

The reset request comes from a small key state machine with three states. KEY_IDLE goes to KEY_FIRE when the key write is present. KEY_FIRE always leaves after one cycle: it goes to KEY_HOLD if the key write is still asserted, and to KEY_IDLE otherwise. KEY_HOLD goes back to KEY_IDLE once the key write drops. The request output is high only in KEY_FIRE.

Top module: `board_ctrl_regs`

## Requirements
- R1: Only address bits [19:0] select a register. Two addresses that differ only above bit 19 reach the same register.
- R2: Reads of offsets that hold no readable register return 0. Writes to such offsets change no output and no readable value.
- R3: Offsets 0x00200 and 0x00210 always read 0 and ignore writes. Offset 0x00208 reads 0x10 when `big_endian` is 0 and 0x12 when it is 1.
- R4: A write to 0x00408 stores bits [7:0]. That byte drives `led_o` and reads back from 0x00408.
- R5: A write to 0x00410 sets display character k (k = 0..7) to the uppercase ASCII hex digit of nibble wdata[31-4k:28-4k]. Digits 0-9 map to 0x30-0x39 and A-F map to 0x41-0x46. Character k appears on `disp_o[8k+7:8k]`.
- R6: A write to offset 0x418 + 8k (k = 0..7) stores wdata[7:0] as display character k. Any other offset in that range leaves the display unchanged.
- R7: A write of exactly 0x00000042 to 0x00500 raises `reset_req_o` for one cycle, starting on the cycle after that write edge. A key write held over several cycles gives one pulse. Any other value gives no pulse.
- R8: Writes to 0x00508 (break/reset byte) and 0x00A00 (general-purpose output) each store bits [7:0], which read back from the same offset.
- R9: 0x00B08 stores bits [1:0] as `i2c_oe_o`. 0x00B18 stores bit 0 as the select bit. 0x00B10 stores the whole word; bit 1 drives `scl_o` and bit 0 drives `sda_o`.
- R10: 0x00A08 reads the 0x00B10 word when select is 1, and 0 when select is 0. 0x00B00 reads 0x2 | `sda_in`.
- R11: After reset: LED = 0, break/reset = 0x0A, general-purpose output = 0, output enable = 0, I2C output word = 0x3, select = 1, every display character = 0x20, `reset_req_o` = 0.
- R12: `bus_rdata` follows `bus_addr` within the same cycle. `bus_rvalid` is high exactly in the cycle after a cycle with `bus_rd` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| big_endian | input | 1 | Byte-order mode shown in the status register |
| bus_addr | input | ADDR_W | Bus address; bits [19:0] are decoded |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| bus_rvalid | output | 1 | Read valid, one cycle after bus_rd |
| sda_in | input | 1 | Live level of the two-wire data line |
| led_o | output | 8 | LED bar |
| disp_o | output | 64 | Display characters, character k at [8k+7:8k] |
| scl_o | output | 1 | Clock-line drive level |
| sda_o | output | 1 | Data-line drive level |
| i2c_oe_o | output | 2 | Two-wire output enables |
| reset_req_o | output | 1 | One-cycle software reset request |

## Verification
The hardest case to reach is the key register's hold behaviour. The key write has to stay asserted across several consecutive cycles, and then be repeated straight after a gap, so that the KEY_FIRE to KEY_HOLD and KEY_HOLD to KEY_IDLE transitions are both taken. The stimulus gets there with a strobe held for three cycles, followed by one idle cycle and a fresh key write. It also sends near-miss values (0x43 and 0x142) that share the key's low bits. Hex-word conversion is driven with words that between them use all sixteen digit values. Address aliasing is exercised by writing through one set of upper bits and reading back through another.

// File: rtl/bcr_pkg.sv
package bcr_pkg;
    localparam int DATA_W = 32;
    localparam int OFF_W  = 20;
    localparam int NCHAR  = DATA_W / 4;

    localparam logic [OFF_W-1:0] OFF_SWITCH  = 20'h00200;
    localparam logic [OFF_W-1:0] OFF_STATUS  = 20'h00208;
    localparam logic [OFF_W-1:0] OFF_JUMPER  = 20'h00210;
    localparam logic [OFF_W-1:0] OFF_LED     = 20'h00408;
    localparam logic [OFF_W-1:0] OFF_HEXWORD = 20'h00410;
    localparam logic [OFF_W-1:0] OFF_CHAR0   = 20'h00418;
    localparam logic [OFF_W-1:0] OFF_SOFTRST = 20'h00500;
    localparam logic [OFF_W-1:0] OFF_BRK     = 20'h00508;
    localparam logic [OFF_W-1:0] OFF_GPOUT   = 20'h00A00;
    localparam logic [OFF_W-1:0] OFF_GPIN    = 20'h00A08;
    localparam logic [OFF_W-1:0] OFF_I2C_IN  = 20'h00B00;
    localparam logic [OFF_W-1:0] OFF_I2C_OE  = 20'h00B08;
    localparam logic [OFF_W-1:0] OFF_I2C_OUT = 20'h00B10;
    localparam logic [OFF_W-1:0] OFF_I2C_SEL = 20'h00B18;

    localparam logic [DATA_W-1:0] SOFTRST_KEY = 32'h0000_0042;
    localparam logic [DATA_W-1:0] STATUS_LE   = 32'h0000_0010;
    localparam logic [DATA_W-1:0] STATUS_BE   = 32'h0000_0012;
    localparam logic [7:0]        BRK_INIT    = 8'h0A;
    localparam logic [7:0]        BLANK_CHAR  = 8'h20;

    typedef enum logic [1:0] {
        KEY_IDLE = 2'd0,
        KEY_FIRE = 2'd1,
        KEY_HOLD = 2'd2
    } key_state_t;

    function automatic logic [7:0] nib2ascii(input logic [3:0] n);
        return (n < 4'd10) ? (8'h30 + {4'h0, n}) : (8'h37 + {4'h0, n});
    endfunction
endpackage

// File: rtl/bcr_display.sv
module bcr_display
    import bcr_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [OFF_W-1:0]       off,
    input  logic [DATA_W-1:0]      wdata,
    output logic [8*NCHAR-1:0]     chars
);
    for (genvar i = 0; i < NCHAR; i++) begin : g_slot
        localparam logic [OFF_W-1:0] SLOT_OFF = OFF_W'(OFF_CHAR0 + 20'(8 * i));
        logic [7:0] slot_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= BLANK_CHAR;
            end else if (wr_en && off == OFF_HEXWORD) begin
                slot_q <= nib2ascii(wdata[DATA_W-1-4*i -: 4]);
            end else if (wr_en && off == SLOT_OFF) begin
                slot_q <= wdata[7:0];
            end
        end

        assign chars[8*i +: 8] = slot_q;

        p_char_wr_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && off == SLOT_OFF) |=> (chars[8*i +: 8] == $past(wdata[7:0])))
            else $error("R6 character slot write not stored");
    end
endmodule

// File: rtl/bcr_reset_key.sv
module bcr_reset_key
    import bcr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic key_wr,
    output logic pulse
);
    key_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_IDLE: if (key_wr)  state_d = KEY_FIRE;
            KEY_FIRE: state_d = key_wr ? KEY_HOLD : KEY_IDLE;
            KEY_HOLD: if (!key_wr) state_d = KEY_IDLE;
            default:  state_d = KEY_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        pulse = (state_q == KEY_FIRE);
    end

    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |=> !pulse)
        else $error("R7 reset request wider than one cycle");

    p_no_key_no_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !key_wr |=> !pulse)
        else $error("R7 reset request without key write");
endmodule

// File: rtl/bcr_i2c_port.sv
module bcr_i2c_port
    import bcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  off,
    input  logic [DATA_W-1:0] wdata,
    input  logic              sda_in,
    output logic [1:0]        oe,
    output logic [DATA_W-1:0] out_word,
    output logic              sel,
    output logic [DATA_W-1:0] in_word,
    output logic              scl_o,
    output logic              sda_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe       <= 2'b00;
            out_word <= DATA_W'(3);
            sel      <= 1'b1;
        end else if (wr_en) begin
            if (off == OFF_I2C_OE)  oe       <= wdata[1:0];
            if (off == OFF_I2C_OUT) out_word <= wdata;
            if (off == OFF_I2C_SEL) sel      <= wdata[0];
        end
    end

    assign scl_o   = out_word[1];
    assign sda_o   = out_word[0];
    assign in_word = {{(DATA_W-2){1'b0}}, 1'b1, sda_in};

    p_pins_follow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && off == OFF_I2C_OUT) |=>
            (scl_o == $past(wdata[1]) && sda_o == $past(wdata[0])))
        else $error("R9 line drive does not follow output write");
endmodule

// File: rtl/board_ctrl_regs.sv
module board_ctrl_regs
    import bcr_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 big_endian,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 bus_rvalid,
    input  logic                 sda_in,
    output logic [7:0]           led_o,
    output logic [8*NCHAR-1:0]   disp_o,
    output logic                 scl_o,
    output logic                 sda_o,
    output logic [1:0]           i2c_oe_o,
    output logic                 reset_req_o
);
    logic [OFF_W-1:0]  off;
    logic              unused_addr_hi;
    logic [7:0]        led_q, brk_q, gpout_q;
    logic [DATA_W-1:0] i2c_out_word, i2c_in_word;
    logic              i2c_sel;
    logic              key_wr;

    assign off            = bus_addr[OFF_W-1:0];
    assign unused_addr_hi = ^bus_addr[ADDR_W-1:OFF_W];
    assign key_wr         = bus_wr && off == OFF_SOFTRST && bus_wdata == SOFTRST_KEY;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            led_q      <= 8'h00;
            brk_q      <= BRK_INIT;
            gpout_q    <= 8'h00;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_rd;
            if (bus_wr) begin
                if (off == OFF_LED)   led_q   <= bus_wdata[7:0];
                if (off == OFF_BRK)   brk_q   <= bus_wdata[7:0];
                if (off == OFF_GPOUT) gpout_q <= bus_wdata[7:0];
            end
        end
    end

    bcr_display u_display (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (bus_wr),
        .off   (off),
        .wdata (bus_wdata),
        .chars (disp_o)
    );

    bcr_i2c_port u_i2c (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (bus_wr),
        .off      (off),
        .wdata    (bus_wdata),
        .sda_in   (sda_in),
        .oe       (i2c_oe_o),
        .out_word (i2c_out_word),
        .sel      (i2c_sel),
        .in_word  (i2c_in_word),
        .scl_o    (scl_o),
        .sda_o    (sda_o)
    );

    bcr_reset_key u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .key_wr (key_wr),
        .pulse  (reset_req_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (off)
            OFF_STATUS:  bus_rdata = big_endian ? STATUS_BE : STATUS_LE;
            OFF_LED:     bus_rdata = {{(DATA_W-8){1'b0}}, led_q};
            OFF_BRK:     bus_rdata = {{(DATA_W-8){1'b0}}, brk_q};
            OFF_GPOUT:   bus_rdata = {{(DATA_W-8){1'b0}}, gpout_q};
            OFF_GPIN:    bus_rdata = i2c_sel ? i2c_out_word : '0;
            OFF_I2C_IN:  bus_rdata = i2c_in_word;
            OFF_I2C_OE:  bus_rdata = {{(DATA_W-2){1'b0}}, i2c_oe_o};
            OFF_I2C_OUT: bus_rdata = i2c_out_word;
            OFF_I2C_SEL: bus_rdata = {{(DATA_W-1){1'b0}}, i2c_sel};
            default:     bus_rdata = '0;
        endcase
    end

    assign led_o = led_q;

    p_led_wr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFF_LED) |=> (led_o == $past(bus_wdata[7:0])))
        else $error("R4 LED byte not stored");

    p_rvalid_rd_r12: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> bus_rvalid)
        else $error("R12 read valid missing");

    p_rvalid_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !bus_rvalid)
        else $error("R12 read valid without read");
endmodule

// File: tb/test_board_ctrl_regs.sv
`timescale 1ns/1ps
module test_board_ctrl_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        big_endian = 1'b0;
    logic [31:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        sda_in = 1'b1;
    logic [7:0]  led_o;
    logic [63:0] disp_o;
    logic        scl_o, sda_o;
    logic [1:0]  i2c_oe_o;
    logic        reset_req_o;

    always #2 clk = ~clk;

    board_ctrl_regs i_board_ctrl_regs (
        .clk(clk), .rst_n(rst_n), .big_endian(big_endian),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .sda_in(sda_in), .led_o(led_o), .disp_o(disp_o), .scl_o(scl_o),
        .sda_o(sda_o), .i2c_oe_o(i2c_oe_o), .reset_req_o(reset_req_o)
    );

    int    n_run = 0;
    int    n_fail = 0;
    bit    done = 0;
    string cur_req = "R11";

    logic [7:0]  m_led, m_brk, m_gp;
    logic [1:0]  m_oe;
    logic [31:0] m_out;
    logic        m_sel, m_pulse, m_key_last, m_rvalid;
    logic [7:0]  m_disp [8];

    task automatic chk(string what, logic [63:0] act, logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", cur_req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] hexc(logic [3:0] n);
        if (n < 10) return 8'd48 + 8'(n);
        return 8'd65 + 8'(n) - 8'd10;
    endfunction

    task automatic m_reset();
        m_led = 0; m_brk = 8'h0A; m_gp = 0; m_oe = 0; m_out = 32'h3; m_sel = 1;
        m_pulse = 0; m_key_last = 0; m_rvalid = 0;
        for (int k = 0; k < 8; k++) m_disp[k] = 8'h20;
    endtask

    function automatic logic [31:0] m_read(logic [31:0] a);
        logic [19:0] o = a[19:0];
        case (o)
            20'h00208: return big_endian ? 32'h12 : 32'h10;
            20'h00408: return {24'h0, m_led};
            20'h00508: return {24'h0, m_brk};
            20'h00A00: return {24'h0, m_gp};
            20'h00A08: return m_sel ? m_out : 32'h0;
            20'h00B00: return {30'h0, 1'b1, sda_in};
            20'h00B08: return {30'h0, m_oe};
            20'h00B10: return m_out;
            20'h00B18: return {31'h0, m_sel};
            default:   return 32'h0;
        endcase
    endfunction

    task automatic check_outs();
        chk("led_o", 64'(led_o), 64'(m_led));
        for (int k = 0; k < 8; k++) chk($sformatf("disp[%0d]", k), 64'(disp_o[8*k +: 8]), 64'(m_disp[k]));
        chk("scl_o", 64'(scl_o), 64'(m_out[1]));
        chk("sda_o", 64'(sda_o), 64'(m_out[0]));
        chk("i2c_oe_o", 64'(i2c_oe_o), 64'(m_oe));
        chk("reset_req_o", 64'(reset_req_o), 64'(m_pulse));
        chk("bus_rvalid", 64'(bus_rvalid), 64'(m_rvalid));
    endtask

    task automatic cyc(bit wr, bit rd, logic [31:0] a, logic [31:0] d);
        logic [19:0] o;
        bit key;
        @(negedge clk);
        check_outs();
        bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
        #1;
        if (rd) chk("bus_rdata", 64'(bus_rdata), 64'(m_read(a)));
        o = a[19:0];
        m_rvalid = rd;
        key = wr && o == 20'h00500 && d == 32'h42;
        m_pulse = key && !m_key_last;
        m_key_last = key;
        if (wr) begin
            if (o == 20'h00408) m_led = d[7:0];
            if (o == 20'h00508) m_brk = d[7:0];
            if (o == 20'h00A00) m_gp = d[7:0];
            if (o == 20'h00B08) m_oe = d[1:0];
            if (o == 20'h00B10) m_out = d;
            if (o == 20'h00B18) m_sel = d[0];
            if (o == 20'h00410)
                for (int k = 0; k < 8; k++) m_disp[k] = hexc(d[31-4*k -: 4]);
            if (o >= 20'h00418 && o <= 20'h00450 && o[2:0] == 3'b000)
                m_disp[(o - 20'h00418) >> 3] = d[7:0];
        end
    endtask

    task automatic wr(logic [31:0] a, logic [31:0] d); cyc(1, 0, a, d); endtask
    task automatic rd(logic [31:0] a);                 cyc(0, 1, a, 32'h0); endtask
    task automatic idle();                             cyc(0, 0, 32'h0, 32'h0); endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog %s: actual timeout expected completion", cur_req);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        m_reset();
        repeat (3) @(negedge clk);
        cur_req = "R11";
        check_outs();
        bus_addr = 32'h508; #1;
        chk("brk at reset", 64'(bus_rdata), 64'h0A);
        bus_addr = 32'h0;
        rst_n = 1'b1;
        foreach (m_disp[k]) ;
        rd(32'h408); rd(32'h508); rd(32'hA00); rd(32'hB08); rd(32'hB10); rd(32'hB18);

        cur_req = "R3";
        rd(32'h200); rd(32'h208); rd(32'h210);
        big_endian = 1'b1; rd(32'h208); big_endian = 1'b0; rd(32'h208);
        wr(32'h200, 32'hFFFF_FFFF); wr(32'h210, 32'hFFFF_FFFF); rd(32'h200); rd(32'h210);

        cur_req = "R4";
        wr(32'h408, 32'h1234_56A5); rd(32'h408); wr(32'h408, 32'h0000_0001); rd(32'h408);

        cur_req = "R1";
        wr(32'hFFF0_0408, 32'h0000_003C); rd(32'h1230_0408); rd(32'h0000_0408);
        wr(32'hABC0_0B10, 32'h2); rd(32'h0000_0B10);

        cur_req = "R2";
        wr(32'h404, 32'hFFFF_FFFF); wr(32'hB04, 32'hFFFF_FFFF); wr(32'hFFFFF, 32'h7);
        rd(32'h404); rd(32'h0); rd(32'h410); rd(32'h418); rd(32'h500); rd(32'hFFFFF);

        cur_req = "R5";
        wr(32'h410, 32'hDEAD_BEEF); idle();
        wr(32'h410, 32'h0123_4567); idle();
        wr(32'h410, 32'h89AB_CDEF); idle();

        cur_req = "R6";
        for (int k = 0; k < 8; k++) wr(32'h418 + 32'(8*k), 32'h0000_0161 + 32'(k));
        wr(32'h41C, 32'h55); wr(32'h458, 32'h55); idle();

        cur_req = "R7";
        wr(32'h500, 32'h42); idle(); idle();
        wr(32'h500, 32'h142); wr(32'h500, 32'h43); idle();
        wr(32'h500, 32'h42); wr(32'h500, 32'h42); wr(32'h500, 32'h42); idle();
        wr(32'h500, 32'h42); idle(); idle();

        cur_req = "R8";
        wr(32'h508, 32'h0000_ABCD); rd(32'h508);
        wr(32'hA00, 32'hFFFF_FF5A); rd(32'hA00);

        cur_req = "R9";
        wr(32'hB08, 32'hFFFF_FFFF); rd(32'hB08);
        wr(32'hB10, 32'h0000_0002); wr(32'hB10, 32'h0000_0001); wr(32'hB10, 32'h8000_0003);
        wr(32'hB18, 32'h6); rd(32'hB18);

        cur_req = "R10";
        rd(32'hA08);
        wr(32'hB18, 32'h1); rd(32'hA08);
        sda_in = 1'b0; rd(32'hB00); sda_in = 1'b1; rd(32'hB00);

        cur_req = "R12";
        rd(32'h408); rd(32'h508); idle(); rd(32'hB10); idle(); idle();

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule